// File: doc/BRIEF.md
# Receive Queue Interrupt Vector Tracker

This block sits on the adapter side of a receive path that has several descriptor queues but only one host interrupt. Each time a descriptor lands in a queue, the block sets that queue's bit in a pending bit vector. A moderation interval starts once the vector holds at least one bit and the interrupt is enabled. When the interval has run out, the block copies the vector into an output register, clears the tracking vector and asks for a host memory write of the copy. The interrupt is raised only after that write has been acknowledged.

After the interrupt pulse, the interrupt stays masked until the host sends a re-enable strobe. Tracking for the next report starts again at the instant the copy is taken. So a descriptor that arrives while the write is in flight, or while the interrupt is masked, is kept for the next report and is never lost. If the vector already holds bits when the host re-enables, a new moderation interval starts at once.

Top module: `irq_vector_tracker`

## Requirements
- R1: A descriptor accepted with `desc_valid` high sets bit `desc_queue` of the pending vector. The written `vec_data` has bit i set exactly when a descriptor for queue i was accepted after the previous copy was taken.
- R2: With the interrupt enabled and the moderation limit at T cycles, the copy is taken at the (T+1)th rising edge after the edge that recorded the first pending bit. `vec_req` is high from that edge on.
- R3: While `vec_req` is high and `vec_ack` is low, `vec_req` stays high, `vec_data` holds its value and `irq` stays low.
- R4: An edge with both `vec_req` and `vec_ack` high drops `vec_req` and raises `irq` for exactly one cycle.
- R5: After the `irq` pulse, neither `vec_req` nor `irq` is raised again until `host_reenable` is sampled high. Descriptors that arrive in that time are kept.
- R6: A descriptor sampled on the same edge that takes the copy goes into the next vector and not into the one being written.
- R7: A re-enable that finds a non-empty vector starts the moderation interval at once. The copy is taken T+1 edges after the re-enable edge.
- R8: An empty vector never causes a write request or an interrupt, even after a re-enable.
- R9: After a synchronous reset, `vec_req` and `irq` are low, the vector is empty and the interrupt is enabled.
- R10: `vec_ack` sampled while `vec_req` is low has no effect and raises no `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | A descriptor landed this cycle |
| desc_queue | input | 3 | Queue index of that descriptor |
| mod_limit | input | 16 | Moderation interval in cycles |
| vec_ack | input | 1 | Host memory write of the vector completed |
| host_reenable | input | 1 | Host re-enables the interrupt |
| vec_req | output | 1 | Write request for the vector copy |
| vec_data | output | 8 | Vector copy to be written |
| irq | output | 1 | One-cycle host interrupt |

## Verification
The hardest case to reach from the ports is a descriptor that arrives on exactly the edge where the copy is taken. The bench counts cycles from the first arrival edge and drives the second descriptor so that it is sampled on edge T+1. It then expects one bit in the write in flight and the other bit in the report that follows the next re-enable. Re-enables are issued both with a pending vector and with an empty one, which covers both the immediate restart of the interval and the silent case.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  typedef enum logic [1:0] {
    ST_ARMED  = 2'd0,
    ST_WRITE  = 2'd1,
    ST_MASKED = 2'd2
  } ivt_state_e;
endpackage

// File: rtl/ivt_pending.sv
// Pending-queue vector: one sticky bit per queue, cleared when the copy is
// taken; an arrival on that same edge survives into the fresh vector.
module ivt_pending #(
  parameter int NQ = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arr_valid,
  input  logic [QW-1:0] arr_idx,
  input  logic          take,
  output logic [NQ-1:0] pend
);
  for (genvar g = 0; g < NQ; g++) begin : g_bit
    logic hit;
    assign hit = arr_valid && (arr_idx == QW'(g));
    always_ff @(posedge clk) begin
      if (rst) pend[g] <= 1'b0;
      else     pend[g] <= (pend[g] & ~take) | hit;
    end
  end
endmodule

// File: rtl/ivt_modtimer.sv
// Moderation interval counter: counts while run is high, restarts otherwise.
module ivt_modtimer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  assign expired = run && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run)       cnt_q <= '0;
    else if (cnt_q < limit) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ivt_sequencer.sv
// Copy / write / interrupt / mask sequence.
module ivt_sequencer
  import ivt_pkg::*;
#(
  parameter int NQ = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NQ-1:0] pend,
  input  logic          expired,
  input  logic          vec_ack,
  input  logic          host_reenable,
  output logic          take,
  output logic          timer_run,
  output logic          vec_req,
  output logic [NQ-1:0] vec_data,
  output logic          irq
);
  ivt_state_e state_q;
  logic       armed;

  assign armed     = (state_q == ST_ARMED);
  assign timer_run = armed && (|pend);
  assign take      = timer_run && expired;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_ARMED;
      vec_req  <= 1'b0;
      vec_data <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= 1'b0;
      unique case (state_q)
        ST_ARMED: if (take) begin
          vec_data <= pend;
          vec_req  <= 1'b1;
          state_q  <= ST_WRITE;
        end
        ST_WRITE: if (vec_ack) begin
          vec_req <= 1'b0;
          irq     <= 1'b1;
          state_q <= ST_MASKED;
        end
        ST_MASKED: if (host_reenable) state_q <= ST_ARMED;
        default: state_q <= ST_ARMED;
      endcase
    end
  end
endmodule

// File: rtl/irq_vector_tracker.sv
module irq_vector_tracker #(
  parameter int NQ = 8,
  parameter int TW = 16,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          desc_valid,
  input  logic [QW-1:0] desc_queue,
  input  logic [TW-1:0] mod_limit,
  input  logic          vec_ack,
  input  logic          host_reenable,
  output logic          vec_req,
  output logic [NQ-1:0] vec_data,
  output logic          irq
);
  logic [NQ-1:0] pend;
  logic          take;
  logic          timer_run;
  logic          expired;

  ivt_pending #(.NQ(NQ)) u_pend (
    .clk(clk), .rst(rst), .arr_valid(desc_valid), .arr_idx(desc_queue),
    .take(take), .pend(pend)
  );

  ivt_modtimer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .run(timer_run), .limit(mod_limit), .expired(expired)
  );

  ivt_sequencer #(.NQ(NQ)) u_seq (
    .clk(clk), .rst(rst), .pend(pend), .expired(expired), .vec_ack(vec_ack),
    .host_reenable(host_reenable), .take(take), .timer_run(timer_run),
    .vec_req(vec_req), .vec_data(vec_data), .irq(irq)
  );
endmodule

// File: rtl/irq_vector_tracker_chk.sv
module irq_vector_tracker_chk #(
  parameter int NQ = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          vec_ack,
  input logic          host_reenable,
  input logic          vec_req,
  input logic [NQ-1:0] vec_data,
  input logic          irq
);
  logic masked;
  always_ff @(posedge clk) begin
    if (rst)                masked <= 1'b0;
    else if (host_reenable) masked <= 1'b0;
    else if (irq)           masked <= 1'b1;
  end

  p_hold_req_r3: assert property (@(posedge clk) disable iff (rst)
    (vec_req && !vec_ack) |=> (vec_req && $stable(vec_data) && !irq));

  p_irq_single_r4: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_irq_after_ack_r4: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(vec_req && vec_ack));

  p_ack_drops_req_r4: assert property (@(posedge clk) disable iff (rst)
    (vec_req && vec_ack) |=> (!vec_req && irq));

  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    masked |-> (!vec_req && !irq));

  p_nonempty_r8: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> (vec_data != '0));
endmodule

bind irq_vector_tracker irq_vector_tracker_chk #(.NQ(NQ)) u_chk (
  .clk(clk), .rst(rst), .vec_ack(vec_ack), .host_reenable(host_reenable),
  .vec_req(vec_req), .vec_data(vec_data), .irq(irq)
);

// File: tb/irq_vector_tracker_test.sv
module irq_vector_tracker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        desc_valid = 1'b0;
  logic [2:0]  desc_queue = '0;
  logic [15:0] mod_limit = 16'd5;
  logic        vec_ack = 1'b0;
  logic        host_reenable = 1'b0;
  logic        vec_req;
  logic [7:0]  vec_data;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int n_writes = 0;
  logic req_seen = 1'b0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_vector_tracker uut (
    .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_queue(desc_queue),
    .mod_limit(mod_limit), .vec_ack(vec_ack), .host_reenable(host_reenable),
    .vec_req(vec_req), .vec_data(vec_data), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: every new write request is compared against the scoreboard.
  always @(negedge clk) begin
    if (!rst) begin
      if (vec_req && !req_seen) begin
        n_writes++;
        if (exp_q.size() == 0) check(1'b0, "R1 unexpected write", int'(vec_data), 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(vec_data == e, "R1 R6 vector contents", int'(vec_data), int'(e));
        end
      end
      req_seen = vec_req;
    end
  end

  task automatic send(input int q);
    desc_valid = 1'b1;
    desc_queue = 3'(q);
    @(negedge clk);
    desc_valid = 1'b0;
  endtask

  task automatic wait_req(output int t);
    for (int i = 0; i < 100 && !vec_req; i++) @(negedge clk);
    t = cyc;
  endtask

  task automatic ack_it();
    vec_ack = 1'b1;
    @(negedge clk);
    vec_ack = 1'b0;
    check(irq == 1'b1, "R4 irq after ack", irq, 1);
    check(vec_req == 1'b0, "R4 req drops on ack", vec_req, 0);
    @(negedge clk);
    check(irq == 1'b0, "R4 irq one cycle", irq, 0);
  endtask

  task automatic reenable(output int t);
    host_reenable = 1'b1;
    @(negedge clk);
    host_reenable = 1'b0;
    t = cyc;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int t0, t;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(vec_req == 1'b0, "R9 reset req", vec_req, 0);
    check(irq == 1'b0, "R9 reset irq", irq, 0);

    // R8: nothing pending, nothing happens
    repeat (20) @(negedge clk);
    check(n_writes == 0, "R8 idle no write", n_writes, 0);

    // R10: stray ack with no request
    vec_ack = 1'b1; @(negedge clk); vec_ack = 1'b0; @(negedge clk);
    check(irq == 1'b0, "R10 stray ack ignored", irq, 0);

    // R1 R2: three arrivals, two queues
    exp_q.push_back(8'h24);
    send(2); t0 = cyc; send(5); send(2);
    wait_req(t);
    check(t - t0 == 6, "R2 moderation delay", t - t0, 6);

    // R3: hold without ack
    repeat (4) @(negedge clk);
    check(vec_req == 1'b1, "R3 request held", vec_req, 1);
    check(irq == 1'b0, "R3 no irq before ack", irq, 0);
    check(vec_data == 8'h24, "R3 data stable", vec_data, 8'h24);
    ack_it();

    // R5: arrival while masked is kept, nothing raised
    send(7);
    repeat (20) @(negedge clk);
    check(vec_req == 1'b0 && n_writes == 1, "R5 masked no request", n_writes, 1);
    vec_ack = 1'b1; @(negedge clk); vec_ack = 1'b0; @(negedge clk);
    check(irq == 1'b0, "R5 R10 masked ack ignored", irq, 0);

    // R7: re-enable with pending vector
    exp_q.push_back(8'h80);
    reenable(t0);
    wait_req(t);
    check(t - t0 == 6, "R7 immediate restart", t - t0, 6);
    ack_it();

    // R8: re-enable with empty vector
    reenable(t0);
    repeat (30) @(negedge clk);
    check(n_writes == 2, "R8 empty after reenable", n_writes, 2);

    // R6: arrival on the copy edge
    exp_q.push_back(8'h02);
    exp_q.push_back(8'h10);
    send(1); t0 = cyc;
    repeat (5) @(negedge clk);
    send(4);
    check(vec_req == 1'b1 && cyc - t0 == 6, "R6 copy edge", cyc - t0, 6);
    ack_it();
    reenable(t0);
    wait_req(t);
    check(t - t0 == 6, "R6 R7 late arrival reported next", t - t0, 6);
    ack_it();

    // R2: zero-cycle moderation limit
    mod_limit = 16'd0;
    exp_q.push_back(8'h08);
    reenable(t0);
    send(3); t0 = cyc;
    wait_req(t);
    check(t - t0 == 1, "R2 zero limit", t - t0, 1);
    ack_it();

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
    check(n_writes == 5, "R1 write count", n_writes, 5);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule